// File: doc/BRIEF.md
# Palette Colour Table Access Port

This block holds a small RGB colour palette in flip-flops and gives a host sequential access to it through two registers on a simple synchronous register bus. The host sets an entry pointer through the index register. It then moves colour components through the component register, which is a single register. Each access to the component register steps the port through red, green and blue. After blue, the port moves on to the next entry. The host therefore never has to rewrite the index while it streams a whole palette.

Written components are held in staging registers. The palette entry is replaced in one step, only when the blue component arrives. A display pipeline that reads the palette never sees a half-updated colour. The pipeline reads through a separate combinational lookup port that maps a pixel index to its 12-bit colour.

Top module: `pal_lut_port`

## Requirements
- R1: After reset, the entry pointer is 0, the component phase is red, and every palette entry reads as 12'h000 on the lookup port.
- R2: A write with `reg_sel`=0 loads the entry pointer from `wdata[3:0]` and returns the phase to red. A read with `reg_sel`=0 returns the pointer in `rdata[3:0]`, with the upper bits 0.
- R3: Writes to the component register in the red and green phases only stage the value. No palette entry changes on those writes.
- R4: A component write in the blue phase replaces the current entry with {staged red, staged green, `wdata[7:4]`}. The result appears on `pix_rgb` from the next clock on.
- R5: Every component-register access steps the phase in the order red, green, blue. The access in the blue phase also adds one to the pointer, and the pointer wraps from 15 to 0.
- R6: A component read returns the current entry's component for the current phase in `rdata[7:4]`, with `rdata[3:0]`=0. The order is red, then green, then blue.
- R7: A component read advances the phase and the pointer exactly as a component write does, and it leaves the palette unchanged.
- R8: An index-register write discards partly staged components. After it, a blue commit uses 0 for any red or green component that was not written again.
- R9: `rdata` is 0 in any cycle where `rd_en` is low.
- R10: When `wr_en` and `rd_en` are high together, the access acts as a write only, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the component register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational in the strobe cycle |
| pix_idx | input | 4 | Pixel index for the lookup port |
| pix_rgb | output | 12 | Colour {R,G,B} at `pix_idx` |

## Verification
A wrong phase or pointer shows up on the next component read, which returns the wrong nibble or the wrong entry. The mismatch also reaches the lookup port, one clock after the blue write lands in the wrong entry. Staging faults stay hidden until the following blue commit, and then appear on `pix_rgb` one clock later. For that reason, the bench compares `rdata` and `pix_rgb` against a behavioural model on every clock. It also sweeps the lookup index while it streams data.

// File: rtl/lut_pkg.sv
package lut_pkg;
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;
endpackage

// File: rtl/lut_seq.sv
// Entry pointer and component-phase sequencer.
module lut_seq
   import lut_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_wr,
   input  logic             data_acc,
   input  logic [IDX_W-1:0] ptr_load,
   output logic [IDX_W-1:0] ptr,
   output phase_e           phase
);
   localparam logic [IDX_W-1:0] PTR_ONE = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= PH_RED;
      end else if (addr_wr) begin
         ptr   <= ptr_load;
         phase <= PH_RED;
      end else if (data_acc) begin
         unique case (phase)
            PH_RED:  phase <= PH_GRN;
            PH_GRN:  phase <= PH_BLU;
            default: begin
               phase <= PH_RED;
               ptr   <= ptr + PTR_ONE;
            end
         endcase
      end
   end

   // R2: index write loads the pointer and restarts the phase at red
   p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wr |=> (ptr == $past(ptr_load)) && (phase == PH_RED));

   // R5: the blue-phase access on the last entry wraps the pointer to 0
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !addr_wr && phase == PH_BLU && ptr == '1) |=> (ptr == '0));

   // R7: with no access, pointer and phase stay put
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_wr && !data_acc) |=> ($stable(ptr) && $stable(phase)));

   // R5: the phase never leaves its three legal codes
   p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);
endmodule

// File: rtl/lut_stage.sv
// Holding registers for the red and green components.
module lut_stage
   import lut_pkg::*;
#(
   parameter int CMP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  phase_e           phase,
   input  logic [CMP_W-1:0] comp_in,
   output logic [CMP_W-1:0] st_r,
   output logic [CMP_W-1:0] st_g
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_r <= '0;
         st_g <= '0;
      end else if (clr) begin
         st_r <= '0;
         st_g <= '0;
      end else if (wr) begin
         if (phase == PH_RED) st_r <= comp_in;
         if (phase == PH_GRN) st_g <= comp_in;
      end
   end

   // R8: an index write empties the staging registers
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st_r == '0) && (st_g == '0));
endmodule

// File: rtl/lut_store.sv
// Flip-flop palette with one write port, one host read port and one lookup port.
module lut_store #(
   parameter int IDX_W = 4,
   parameter int CMP_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [IDX_W-1:0]   wptr,
   input  logic [CMP_W-1:0]   in_r,
   input  logic [CMP_W-1:0]   in_g,
   input  logic [CMP_W-1:0]   in_b,
   input  logic [IDX_W-1:0]   hptr,
   output logic [3*CMP_W-1:0] h_rgb,
   input  logic [IDX_W-1:0]   pix_idx,
   output logic [3*CMP_W-1:0] pix_rgb
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int RGB_W = 3 * CMP_W;

   logic [RGB_W-1:0]       tbl [DEPTH];
   logic [DEPTH*RGB_W-1:0] tbl_flat;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl[e] <= '0;
         else if (commit && wptr == IDX_W'(e))
            tbl[e] <= {in_r, in_g, in_b};
      end
      assign tbl_flat[e*RGB_W +: RGB_W] = tbl[e];
   end

   assign h_rgb   = tbl[hptr];
   assign pix_rgb = tbl[pix_idx];

   // R4: a commit lands the staged colour in the addressed entry
   p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (tbl[$past(wptr)] == $past({in_r, in_g, in_b})));

   // R3: without a commit no entry changes
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(tbl_flat));
endmodule

// File: rtl/pal_lut_port.sv
// Register-bus access port to the palette colour table.
module pal_lut_port
   import lut_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int CMP_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [IDX_W-1:0]    pix_idx,
   output logic [3*CMP_W-1:0]  pix_rgb
);
   localparam int LOW_W = DATA_W - CMP_W;
   localparam int PAD_W = DATA_W - IDX_W;

   if (CMP_W >= DATA_W) begin : g_bad_cmp
      $error("CMP_W must be narrower than DATA_W");
   end
   if (IDX_W >= DATA_W) begin : g_bad_idx
      $error("IDX_W must be narrower than DATA_W");
   end

   logic               addr_wr, data_acc, data_wr, data_rd, commit;
   logic [IDX_W-1:0]   ptr;
   phase_e             phase;
   logic [CMP_W-1:0]   comp_in, st_r, st_g, comp_out;
   logic [3*CMP_W-1:0] h_rgb;

   assign addr_wr  = !reg_sel && wr_en;
   assign data_wr  = reg_sel && wr_en;
   assign data_rd  = reg_sel && rd_en && !wr_en;
   assign data_acc = data_wr || data_rd;
   assign comp_in  = wdata[DATA_W-1 -: CMP_W];
   assign commit   = data_wr && (phase == PH_BLU);

   lut_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_acc(data_acc),
      .ptr_load(wdata[IDX_W-1:0]), .ptr(ptr), .phase(phase)
   );

   lut_stage #(.CMP_W(CMP_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .clr(addr_wr), .wr(data_wr), .phase(phase),
      .comp_in(comp_in), .st_r(st_r), .st_g(st_g)
   );

   lut_store #(.IDX_W(IDX_W), .CMP_W(CMP_W)) u_store (
      .clk(clk), .rst_n(rst_n), .commit(commit), .wptr(ptr),
      .in_r(st_r), .in_g(st_g), .in_b(comp_in),
      .hptr(ptr), .h_rgb(h_rgb), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   always_comb begin
      unique case (phase)
         PH_RED:  comp_out = h_rgb[3*CMP_W-1 -: CMP_W];
         PH_GRN:  comp_out = h_rgb[2*CMP_W-1 -: CMP_W];
         default: comp_out = h_rgb[CMP_W-1:0];
      endcase
   end

   always_comb begin
      rdata = '0;
      if (rd_en && !wr_en) begin
         if (reg_sel) rdata = {comp_out, {LOW_W{1'b0}}};
         else         rdata = {{PAD_W{1'b0}}, ptr};
      end
   end

   // R6: component reads carry zeros below the component field
   p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |-> (rdata[LOW_W-1:0] == '0));

   // R9, R10: read data is driven only for a read without a write
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || wr_en) |-> (rdata == '0));
endmodule

// File: tb/sim_pal_lut_port.sv
module sim_pal_lut_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] pix_idx = '0;
   logic [11:0] pix_rgb;

   int compared = 0;
   int mismatched = 0;

   int m_tbl [16];
   int m_ptr = 0, m_ph = 0, m_sr = 0, m_sg = 0;

   always #4 clk = ~clk;

   pal_lut_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   task automatic chk(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int m_rdata(bit sel, bit wr, bit rd);
      int c;
      if (!rd || wr) return 0;
      if (!sel) return m_ptr;
      c = (m_tbl[m_ptr] >> (4 * (2 - m_ph))) & 15;
      return c << 4;
   endfunction

   // one bus cycle: drive at negedge, compare before posedge, update model at posedge
   task automatic step(string tag, bit sel, bit wr, bit rd, int wd, int pix);
      @(negedge clk);
      reg_sel = sel; wr_en = wr; rd_en = rd; wdata = 8'(wd); pix_idx = 4'(pix);
      #2;
      chk({tag, " rdata"}, int'(rdata), m_rdata(sel, wr, rd));
      chk({tag, " pix_rgb"}, int'(pix_rgb), m_tbl[pix]);
      @(posedge clk);
      if (wr && !sel) begin
         m_ptr = wd & 15; m_ph = 0; m_sr = 0; m_sg = 0;
      end else if (sel && (wr || rd)) begin
         if (wr) begin
            if (m_ph == 0) m_sr = (wd >> 4) & 15;
            else if (m_ph == 1) m_sg = (wd >> 4) & 15;
            else m_tbl[m_ptr] = (m_sr << 8) | (m_sg << 4) | ((wd >> 4) & 15);
         end
         if (m_ph == 2) begin m_ph = 0; m_ptr = (m_ptr + 1) % 16; end
         else m_ph++;
      end
   endtask

   task automatic idle_chk(string tag, int pix, int exp_rgb);
      @(negedge clk);
      reg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pix_idx = 4'(pix);
      #2;
      chk(tag, int'(pix_rgb), exp_rgb);
   endtask

   task automatic rd_addr_chk(string tag, int exp_ptr);
      @(negedge clk);
      reg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b1;
      #2;
      chk(tag, int'(rdata), exp_ptr);
      @(posedge clk);
   endtask

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int seed;
      for (int i = 0; i < 16; i++) m_tbl[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 16; i++) idle_chk("R1 reset entry", i, 0);
      rd_addr_chk("R1 reset pointer", 0);

      // R3, R4: staged write to entry 3
      step("R2 load", 0, 1, 0, 3, 3);
      step("R3 red", 1, 1, 0, 8'hA0, 3);
      idle_chk("R3 after red", 3, 0);
      step("R3 green", 1, 1, 0, 8'h50, 3);
      idle_chk("R3 after green", 3, 0);
      step("R4 blue", 1, 1, 0, 8'hC7, 3);
      idle_chk("R4 commit visible", 3, 12'hA5C);
      rd_addr_chk("R5 advance", 4);

      // R6, R7: read back entry 3
      step("R2 reload", 0, 1, 0, 3, 0);
      step("R6 read red", 1, 0, 1, 0, 3);
      step("R6 read green", 1, 0, 1, 0, 3);
      step("R6 read blue", 1, 0, 1, 0, 3);
      rd_addr_chk("R7 read advances", 4);
      idle_chk("R7 read leaves table", 3, 12'hA5C);

      // R5: wrap
      step("R2 load 15", 0, 1, 0, 15, 15);
      step("R5 r", 1, 1, 0, 8'h10, 15);
      step("R5 g", 1, 1, 0, 8'h20, 15);
      step("R5 b", 1, 1, 0, 8'h30, 15);
      rd_addr_chk("R5 wrap", 0);
      idle_chk("R4 entry 15", 15, 12'h123);

      // R8: discard partial staging
      step("R8 load", 0, 1, 0, 5, 5);
      step("R8 red", 1, 1, 0, 8'h70, 5);
      step("R8 green", 1, 1, 0, 8'h60, 5);
      step("R8 reload", 0, 1, 0, 5, 5);
      step("R8 skip r", 1, 0, 1, 0, 5);
      step("R8 skip g", 1, 0, 1, 0, 5);
      step("R8 blue", 1, 1, 0, 8'h90, 5);
      idle_chk("R8 discarded", 5, 12'h009);

      // R2: index write mid-entry restarts at red
      step("R2 load 3", 0, 1, 0, 3, 0);
      step("R2 read r", 1, 0, 1, 0, 0);
      step("R2 load 3 again", 0, 1, 0, 3, 0);
      step("R2 read r again", 1, 0, 1, 0, 3);

      // R10: write plus read acts as write
      step("R10 load 8", 0, 1, 0, 8, 8);
      step("R10 r", 1, 1, 1, 8'hE0, 8);
      step("R10 g", 1, 1, 1, 8'hD0, 8);
      step("R10 b", 1, 1, 1, 8'hB0, 8);
      idle_chk("R10 committed", 8, 12'hEDB);

      // R9: idle read data
      step("R9 idle", 1, 0, 0, 8'hFF, 8);
      step("R9 idle addr", 0, 0, 0, 8'hFF, 8);

      // mixed traffic, compared every clock
      seed = 32'h1D2C3B4A;
      for (int n = 0; n < 600; n++) begin
         int r;
         seed = seed * 1103515245 + 12345;
         r = (seed >>> 8) & 32'hFFFF;
         if ((r & 31) == 0) step("R2 rand", 0, 1, 0, r >> 5, r >> 12);
         else step("R5 rand", 1, (r >> 5) & 1, (r >> 6) & 1, r >> 7, r >> 12);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule